// File: doc/BRIEF.md
# Free-Block Borrow Address Finder

This block lends spare cache blocks to a network interface whose packet queue has run out of room. It keeps an occupancy table of 512 blocks. Each entry has an occupied bit and a borrowed marker. When a borrow request arrives, the block scans the table one 128-bit window per cycle and picks the lowest free block in the first window that has one. The lookup is bounded to four scan cycles. When it finds a block, it marks the block as borrowed and raises a grant. While the grant is high, it drives the cache write strobe with the block address.

When the interface reports that its payload has been written, the block puts the address into a small first-in first-out queue. A later borrow-read pops that queue and frees the block. A release input lets the interface withdraw a request whose blocking has already cleared. A release during the scan aborts it. A release while the grant is high gives the marked block back. If every window is occupied, no grant is given and an all-occupied flag is raised.

The cache's own fills set the occupied bit through a separate port. A query port lets the cache controller read both bits of any block. The cache data storage itself lies outside this block.

Top module: `borrow_finder`

## Requirements
- R1: After reset, grant_o, wr_en_o, all_full_o and rd_valid_o are 0, and every block reads back as neither occupied nor borrowed.
- R2: A request accepted at a clock edge starts a scan of window 0 in the next cycle, and each later cycle scans the next window. The address returned is window*128 + position: bits [8:7] hold the window and bits [6:0] hold the lowest free position in that window. grant_o rises at the edge that ends the scan of that window.
- R3: After an accepted request, either grant_o or all_full_o rises within four clock edges.
- R4: If all four windows are occupied, no grant is given. all_full_o rises at the edge that ends the scan of window 3 and stays at 1 until the next request is accepted.
- R5: At the edge that grants a block, both its occupied bit and its borrowed bit are set. A cache fill through occ_set_i sets only the occupied bit.
- R6: While grant_o is 1, wr_en_o is 1 and baddr_o holds the granted address. On wr_done_i, the address enters the queue and grant_o is 0 from the following cycle.
- R7: A release during the scan ends it at that edge. No grant follows, and no block is marked.
- R8: A release while grant_o is 1 drops the grant at that edge. The marked block becomes free again, and nothing is queued.
- R9: rd_valid_o is 1 while the queue holds addresses, and rd_addr_o shows the oldest one. rd_i removes that address and clears both bits of its block.
- R10: A request is ignored when the queue already holds four addresses, or when rel_i is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Borrow request, sampled while idle |
| rel_i | input | 1 | Withdraw the current borrow |
| wr_done_i | input | 1 | Payload written into the granted block |
| occ_set_i | input | 1 | Cache fill marks a block occupied |
| occ_idx_i | input | 9 | Block index of the cache fill |
| rd_i | input | 1 | Pop the oldest borrowed address |
| qry_idx_i | input | 9 | Block index to query |
| grant_o | output | 1 | Block granted, write phase open |
| baddr_o | output | 9 | Granted block address |
| wr_en_o | output | 1 | Cache write strobe for baddr_o |
| all_full_o | output | 1 | Last scan found no free block |
| rd_valid_o | output | 1 | Queue holds at least one address |
| rd_addr_o | output | 9 | Oldest queued address |
| qry_valid_o | output | 1 | Occupied bit of the queried block |
| qry_borrowed_o | output | 1 | Borrowed bit of the queried block |

## Verification
The bench fills earlier windows so that the free block lies at a chosen window and position. It then checks both the address bits and the number of edges before the grant. A design that advanced the window wrongly, or picked the highest free bit, would return the wrong address or the wrong latency. With the table completely filled, the bench expects all_full_o exactly at the fourth scan edge and no grant. An off-by-one window count would either grant a block that does not exist or stall. Release is tested both during the scan and after the grant, and the bench queries the affected block each time. A design that marked the block too early, or never gave it back, would leave it occupied. Queue order, the clearing of bits on pop, and a request refused while the queue is full are checked through the read and query ports.

// File: rtl/borrow_finder_pkg.sv
// Package: shared types of the borrow address finder.
// Assumes: nothing beyond IEEE 1800-2017.
package borrow_finder_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_GRANT  = 2'd2
    } bf_state_e;
endpackage

// File: rtl/bf_window_scan.sv
// Module: finds the lowest zero bit of one window of occupied bits.
// Assumes: WIN_BITS is a power of two; purely combinational.
module bf_window_scan #(
    parameter int WIN_BITS = 128,
    localparam int POS_W = $clog2(WIN_BITS)
) (
    input  logic [WIN_BITS-1:0] win_i,
    output logic                found_o,
    output logic [POS_W-1:0]    pos_o
);
    // Priority pick: the lowest free position wins.
    always_comb begin
        found_o = 1'b0;
        pos_o   = '0;
        for (int i = WIN_BITS - 1; i >= 0; i--) begin
            if (!win_i[i]) begin
                found_o = 1'b1;
                pos_o   = POS_W'(i);
            end
        end
    end
endmodule

// File: rtl/bf_occ_table.sv
// Module: per-block occupied and borrowed bits.
// Assumes: two clear ports and two set ports. Clears are applied first, then sets,
// so a set to the same block in the same cycle wins.
module bf_occ_table #(
    parameter int TABLE_BITS = 512,
    localparam int ADDR_W = $clog2(TABLE_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fill_i,
    input  logic [ADDR_W-1:0]     fill_idx_i,
    input  logic                  mark_i,
    input  logic [ADDR_W-1:0]     mark_idx_i,
    input  logic                  clr_a_i,
    input  logic [ADDR_W-1:0]     clr_a_idx_i,
    input  logic                  clr_b_i,
    input  logic [ADDR_W-1:0]     clr_b_idx_i,
    output logic [TABLE_BITS-1:0] vld_o,
    output logic [TABLE_BITS-1:0] brw_o
);
    logic [TABLE_BITS-1:0] vld_q;
    logic [TABLE_BITS-1:0] brw_q;

    // Update both bit arrays: clears first, then sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            brw_q <= '0;
        end else begin
            if (clr_a_i) begin
                vld_q[clr_a_idx_i] <= 1'b0;
                brw_q[clr_a_idx_i] <= 1'b0;
            end
            if (clr_b_i) begin
                vld_q[clr_b_idx_i] <= 1'b0;
                brw_q[clr_b_idx_i] <= 1'b0;
            end
            if (fill_i) begin
                vld_q[fill_idx_i] <= 1'b1;
            end
            if (mark_i) begin
                vld_q[mark_idx_i] <= 1'b1;
                brw_q[mark_idx_i] <= 1'b1;
            end
        end
    end

    assign vld_o = vld_q;
    assign brw_o = brw_q;
endmodule

// File: rtl/bf_addr_queue.sv
// Module: show-ahead first-in first-out queue of borrowed block addresses.
// Assumes: the caller never pushes when full and never pops when empty.
module bf_addr_queue #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 9,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;

    // Wrap a pointer at DEPTH.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store pushed data.
    always_ff @(posedge clk) begin
        if (push_i) mem_q[wr_q] <= data_i;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= nxt(wr_q);
            if (pop_i)  rd_q <= nxt(rd_q);
            if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
            else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign head_o  = mem_q[rd_q];
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) push_i |-> (!full_o || pop_i)); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o); // R9
endmodule

// File: rtl/borrow_finder.sv
// Module: top of the free-block borrow address finder.
// It scans one window of the occupancy table per cycle and marks and grants the
// lowest free block. It queues the address once the payload is written and frees
// the block when it is read back.
// Assumes: TABLE_BITS and WIN_BITS are powers of two, and WIN_BITS divides TABLE_BITS.
module borrow_finder
    import borrow_finder_pkg::*;
#(
    parameter int TABLE_BITS = 512,
    parameter int WIN_BITS   = 128,
    parameter int Q_DEPTH    = 4,
    localparam int ADDR_W  = $clog2(TABLE_BITS),
    localparam int POS_W   = $clog2(WIN_BITS),
    localparam int NUM_WIN = TABLE_BITS / WIN_BITS,
    localparam int WCNT_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rel_i,
    input  logic              wr_done_i,
    input  logic              occ_set_i,
    input  logic [ADDR_W-1:0] occ_idx_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] qry_idx_i,
    output logic              grant_o,
    output logic [ADDR_W-1:0] baddr_o,
    output logic              wr_en_o,
    output logic              all_full_o,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              qry_valid_o,
    output logic              qry_borrowed_o
);
    bf_state_e             st_q;
    logic [WCNT_W-1:0]     win_q;
    logic [ADDR_W-1:0]     baddr_q;
    logic                  full_q;
    logic [TABLE_BITS-1:0] tbl_vld, tbl_brw;
    logic [WIN_BITS-1:0]   cur_win;
    logic                  found;
    logic [POS_W-1:0]      pos;
    logic                  q_empty, q_full;
    logic [ADDR_W-1:0]     q_head;
    logic                  accept, mark, undo, push, pop;

    // Select the window that the scan counter points at.
    assign cur_win = tbl_vld[win_q * WIN_BITS +: WIN_BITS];

    bf_window_scan #(.WIN_BITS(WIN_BITS)) i_scan (
        .win_i   (cur_win),
        .found_o (found),
        .pos_o   (pos)
    );

    // Decode the control strobes from the state.
    assign accept = (st_q == ST_IDLE) && req_i && !rel_i && !q_full;
    assign mark   = (st_q == ST_SEARCH) && !rel_i && found;
    assign undo   = (st_q == ST_GRANT) && rel_i;
    assign push   = (st_q == ST_GRANT) && !rel_i && wr_done_i;
    assign pop    = rd_i && !q_empty;

    bf_occ_table #(.TABLE_BITS(TABLE_BITS)) i_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_i      (occ_set_i),
        .fill_idx_i  (occ_idx_i),
        .mark_i      (mark),
        .mark_idx_i  ({win_q, pos}),
        .clr_a_i     (pop),
        .clr_a_idx_i (q_head),
        .clr_b_i     (undo),
        .clr_b_idx_i (baddr_q),
        .vld_o       (tbl_vld),
        .brw_o       (tbl_brw)
    );

    bf_addr_queue #(.DEPTH(Q_DEPTH), .DATA_W(ADDR_W)) i_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .data_i  (baddr_q),
        .pop_i   (pop),
        .head_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    // Sequence the steps: scan, then mark and grant, then write, then back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            win_q   <= '0;
            baddr_q <= '0;
            full_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q   <= ST_SEARCH;
                        win_q  <= '0;
                        full_q <= 1'b0;
                    end
                end
                ST_SEARCH: begin
                    if (rel_i) begin
                        st_q <= ST_IDLE;
                    end else if (found) begin
                        st_q    <= ST_GRANT;
                        baddr_q <= {win_q, pos};
                    end else if (win_q == WCNT_W'(NUM_WIN - 1)) begin
                        st_q   <= ST_IDLE;
                        full_q <= 1'b1;
                    end else begin
                        win_q <= win_q + 1'b1;
                    end
                end
                ST_GRANT: begin
                    if (rel_i || wr_done_i) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the outputs.
    assign grant_o        = (st_q == ST_GRANT);
    assign wr_en_o        = (st_q == ST_GRANT);
    assign baddr_o        = baddr_q;
    assign all_full_o     = full_q;
    assign rd_valid_o     = !q_empty;
    assign rd_addr_o      = q_head;
    assign qry_valid_o    = tbl_vld[qry_idx_i];
    assign qry_borrowed_o = tbl_brw[qry_idx_i];

    AST_GRANT_MARKED: assert property (@(posedge clk) disable iff (!rst_n) grant_o |-> (tbl_vld[baddr_o] && tbl_brw[baddr_o])); // R5
    AST_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n) (grant_o && wr_done_i) |=> !grant_o); // R6
    AST_FULL_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n) all_full_o |-> !grant_o); // R4
    AST_REL_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (st_q == ST_SEARCH && rel_i) |=> !grant_o); // R7
    AST_REL_FREE: assert property (@(posedge clk) disable iff (!rst_n) (grant_o && rel_i) |=> !tbl_brw[$past(baddr_o)]); // R8
endmodule

// File: tb/test_borrow_finder.sv
// Bench: directed scenarios for borrow_finder, one task each, each checking its own results.
module test_borrow_finder;
    logic       clk = 1'b0;
    logic       rst_n, req_i, rel_i, wr_done_i, occ_set_i, rd_i;
    logic [8:0] occ_idx_i, qry_idx_i;
    logic       grant_o, wr_en_o, all_full_o, rd_valid_o, qry_valid_o, qry_borrowed_o;
    logic [8:0] baddr_o, rd_addr_o;
    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    borrow_finder i_borrow_finder (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rel_i(rel_i), .wr_done_i(wr_done_i),
        .occ_set_i(occ_set_i), .occ_idx_i(occ_idx_i), .rd_i(rd_i), .qry_idx_i(qry_idx_i),
        .grant_o(grant_o), .baddr_o(baddr_o), .wr_en_o(wr_en_o), .all_full_o(all_full_o),
        .rd_valid_o(rd_valid_o), .rd_addr_o(rd_addr_o), .qry_valid_o(qry_valid_o),
        .qry_borrowed_o(qry_borrowed_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_i = 0; rel_i = 0; wr_done_i = 0; occ_set_i = 0; rd_i = 0;
        occ_idx_i = '0; qry_idx_i = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic fill(input int first, input int last);
        for (int i = first; i <= last; i++) begin
            occ_set_i = 1'b1; occ_idx_i = 9'(i);
            tick();
        end
        occ_set_i = 1'b0;
    endtask

    // Pulse a request and count edges until grant (capped at 10).
    task automatic request(output int lat);
        req_i = 1'b1;
        tick();
        req_i = 1'b0;
        lat = 1;
        while (!grant_o && lat < 10) begin
            tick();
            lat++;
        end
    endtask

    task automatic finish_write();
        wr_done_i = 1'b1;
        tick();
        wr_done_i = 1'b0;
    endtask

    task automatic query(input int idx, output int v, output int b);
        qry_idx_i = 9'(idx);
        #1;
        v = int'(qry_valid_o);
        b = int'(qry_borrowed_o);
    endtask

    task automatic t_reset();
        int v, b;
        do_reset();
        chk("R1 grant", grant_o, 0);
        chk("R1 wr_en", wr_en_o, 0);
        chk("R1 full", all_full_o, 0);
        chk("R1 rd_valid", rd_valid_o, 0);
        query(300, v, b);
        chk("R1 valid bit", v, 0);
        chk("R1 borrowed bit", b, 0);
    endtask

    task automatic t_first_block();
        int lat, v, b;
        do_reset();
        request(lat);
        chk("R2 latency window0", lat, 2);
        chk("R2 addr window0", baddr_o, 0);
        chk("R6 wr_en with grant", wr_en_o, 1);
        query(0, v, b);
        chk("R5 valid set", v, 1);
        chk("R5 borrowed set", b, 1);
        finish_write();
        chk("R6 grant drops", grant_o, 0);
        chk("R6 queued", rd_valid_o, 1);
        chk("R6 queued addr", rd_addr_o, 0);
    endtask

    task automatic t_window_step();
        int lat, v, b;
        do_reset();
        fill(0, 132);
        query(5, v, b);
        chk("R5 fill sets valid", v, 1);
        chk("R5 fill leaves borrowed", b, 0);
        request(lat);
        chk("R2 latency window1", lat, 3);
        chk("R2 addr window1", baddr_o, 133);
        finish_write();
        do_reset();
        fill(0, 383);
        fill(390, 390);
        request(lat);
        chk("R3 latency window3", lat, 5);
        chk("R2 addr window3", baddr_o, 384);
    endtask

    task automatic t_all_full();
        int lat;
        do_reset();
        fill(0, 511);
        req_i = 1'b1;
        tick();
        req_i = 1'b0;
        tick(); tick(); tick();
        chk("R4 full not yet", all_full_o, 0);
        tick();
        chk("R4 full raised", all_full_o, 1);
        chk("R4 no grant", grant_o, 0);
        tick(); tick();
        chk("R4 full held", all_full_o, 1);
        chk("R4 still no grant", grant_o, 0);
    endtask

    task automatic t_release_search();
        int v, b;
        do_reset();
        fill(0, 383);
        req_i = 1'b1;
        tick();
        req_i = 1'b0; rel_i = 1'b1;
        tick();
        rel_i = 1'b0;
        tick(); tick(); tick(); tick();
        chk("R7 no grant", grant_o, 0);
        chk("R7 no full", all_full_o, 0);
        query(384, v, b);
        chk("R7 block not marked", v, 0);
    endtask

    task automatic t_release_grant();
        int lat, v, b;
        do_reset();
        request(lat);
        chk("R8 granted first", grant_o, 1);
        rel_i = 1'b1;
        tick();
        rel_i = 1'b0;
        chk("R8 grant dropped", grant_o, 0);
        chk("R8 nothing queued", rd_valid_o, 0);
        query(0, v, b);
        chk("R8 block freed valid", v, 0);
        chk("R8 block freed borrowed", b, 0);
    endtask

    task automatic t_pop_order();
        int lat, v, b;
        do_reset();
        request(lat); finish_write();
        request(lat);
        chk("R9 second addr", baddr_o, 1);
        finish_write();
        chk("R9 head oldest", rd_addr_o, 0);
        rd_i = 1'b1;
        tick();
        rd_i = 1'b0;
        chk("R9 head next", rd_addr_o, 1);
        query(0, v, b);
        chk("R9 popped block free", v, 0);
        chk("R9 popped borrowed clear", b, 0);
        request(lat);
        chk("R9 freed block reused", baddr_o, 0);
        finish_write();
    endtask

    task automatic t_queue_full();
        int lat;
        do_reset();
        for (int k = 0; k < 4; k++) begin
            request(lat);
            finish_write();
        end
        req_i = 1'b1;
        tick();
        req_i = 1'b0;
        tick(); tick(); tick(); tick(); tick();
        chk("R10 queue full ignores req", grant_o, 0);
        chk("R10 queue full no flag", all_full_o, 0);
        rd_i = 1'b1;
        tick();
        rd_i = 1'b0;
        rel_i = 1'b1; req_i = 1'b1;
        tick();
        rel_i = 1'b0; req_i = 1'b0;
        tick(); tick(); tick();
        chk("R10 req with release ignored", grant_o, 0);
        request(lat);
        chk("R10 accepted after pop", baddr_o, 0);
    endtask

    initial begin
        t_reset();
        t_first_block();
        t_window_step();
        t_all_full();
        t_release_search();
        t_release_grant();
        t_pop_order();
        t_queue_full();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule